// File: doc/BRIEF.md
# Key-Protected Clock Control Registers

This block holds two clock control registers that software cannot change by a single store. The mode register selects the clock source: full-speed PLL, low-power oscillator or external clock. Software switches to the low-power oscillator before a power-down so that wake-up is quicker. The power register sets the core clock divider and the power-down mode. A change to either register only lands when software writes a three-step sequence on a simple 32-bit bus. The steps are an opening key, then the new value, then a closing key. Each register has its own keys, and both keys are written to that register's key address.

The new value waits in a shadow register. It is copied to the live register only on the cycle the correct closing key is written. On the cycle after the copy, a one-cycle commit strobe tells the downstream clock logic that the register has changed. The live values drive the clock system directly and can be read back at any time.

Any access on the bus that is not the expected next step cancels the sequence. This includes a read, a write to another address, or a wrong key value. Idle bus cycles between steps do not cancel it.

Top module: `clk_key_regs`

## Requirements
- R1: After reset, clk_src_o is 0 (full-speed PLL), core_div_o is 0 (divide by 1) and pd_mode_o is 0 (active). Both commit strobes are low, and reads of word addresses 0 and 2 return 0.
- R2: At mode key address 1, writing 0x000000AA, then data to address 0, then 0x00000055 commits the data. clk_src_o and the readback of address 0 take the new value on the edge of the closing-key write. mode_commit_o is high for the cycle that follows that edge.
- R3: At power key address 3, writing 0x00000001, then data to address 2, then 0x000000F4 commits the data. In the data, bits [2:0] set core_div_o (the divider as a power of two) and bits [6:4] set pd_mode_o. pwr_commit_o is high for the cycle that follows the closing-key edge.
- R4: A live register changes only on the cycle its commit strobe rises. The data write alone leaves the outputs and the readback unchanged.
- R5: A wrong opening key or a wrong closing key cancels the sequence. The register keeps its value and no strobe is raised.
- R6: Any read, or any write to another address, between two steps of a sequence cancels that sequence.
- R7: Idle bus cycles (req_i low) between steps do not cancel a sequence.
- R8: A write to a data address outside a sequence has no effect on the live value.
- R9: Each commit strobe lasts exactly one cycle. The two strobes never rise together. A commit of one register leaves the other register's value unchanged.
- R10: A read of address 0 returns the mode value in bits [1:0]. A read of address 2 returns the power value in bits [6:0], with bit 3 and all upper bits zero. Written bits outside these fields are dropped. Reads of the key addresses, reads of any other address and all write cycles return 0.
- R11: After a cancelled sequence, a fresh complete sequence commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, valid while req_i is high and we_i is low |
| clk_src_o | output | 2 | Live clock source select |
| core_div_o | output | 3 | Live core divider exponent |
| pd_mode_o | output | 3 | Live power-down mode |
| mode_commit_o | output | 1 | One-cycle strobe after a mode commit |
| pwr_commit_o | output | 1 | One-cycle strobe after a power commit |

## Verification
The assertions check, on every cycle, the following:
- Every commit strobe is preceded by the matching closing key on the bus.
- A live value moves only when its strobe is up.
- Each strobe is one cycle long, and the two strobes are never high together.
- Non-data reads and write cycles return zero.

Some behaviours can only be shown by the bench's scenarios, because each depends on a whole history of accesses:
- a sequence is cancelled by a wrong key or by an intervening read or write;
- idle gaps do not cancel a sequence;
- stray data writes are ignored;
- a sequence restarts cleanly after a cancel.

// File: rtl/clk_key_pkg.sv
package clk_key_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 8;
  localparam int N_REG  = 2;

  // register index; data word at 2*idx, key word at 2*idx+1
  localparam int IDX_MODE = 0;
  localparam int IDX_PWR  = 1;

  localparam logic [BUS_W-1:0] MODE_PRE  = 32'h0000_00AA;
  localparam logic [BUS_W-1:0] MODE_POST = 32'h0000_0055;
  localparam logic [BUS_W-1:0] PWR_PRE   = 32'h0000_0001;
  localparam logic [BUS_W-1:0] PWR_POST  = 32'h0000_00F4;

  localparam logic [REG_W-1:0] MODE_MASK = 8'h03;
  localparam logic [REG_W-1:0] PWR_MASK  = 8'h77;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_STAGED = 2'd2
  } seq_state_e;

  function automatic logic [BUS_W-1:0] pre_key(input int idx);
    return (idx == IDX_MODE) ? MODE_PRE : PWR_PRE;
  endfunction

  function automatic logic [BUS_W-1:0] post_key(input int idx);
    return (idx == IDX_MODE) ? MODE_POST : PWR_POST;
  endfunction

  function automatic logic [REG_W-1:0] wr_mask(input int idx);
    return (idx == IDX_MODE) ? MODE_MASK : PWR_MASK;
  endfunction

  function automatic logic [ADDR_W-1:0] data_addr(input int idx);
    return ADDR_W'(2 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] key_addr(input int idx);
    return ADDR_W'(2 * idx + 1);
  endfunction
endpackage

// File: rtl/clk_key_seq.sv
module clk_key_seq
  import clk_key_pkg::*;
#(
  parameter int               BUS_W_P   = 32,
  parameter int               ADDR_W_P  = 4,
  parameter int               REG_W_P   = 8,
  parameter logic [BUS_W_P-1:0]  PRE_KEY   = '0,
  parameter logic [BUS_W_P-1:0]  POST_KEY  = '0,
  parameter logic [ADDR_W_P-1:0] KEY_ADDR  = '0,
  parameter logic [ADDR_W_P-1:0] DATA_ADDR = '0,
  parameter logic [REG_W_P-1:0]  MASK      = '1,
  parameter logic [REG_W_P-1:0]  RST_VAL   = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W_P-1:0] addr_i,
  input  logic [BUS_W_P-1:0]  wdata_i,
  output logic [REG_W_P-1:0]  live_o,
  output logic                commit_o
);
  seq_state_e         state_q, state_d;
  logic [REG_W_P-1:0] shadow_q;
  logic               wr, hit_pre, hit_data, hit_post;
  logic               stage_en, commit_en;

  assign wr       = req_i & we_i;
  assign hit_pre  = wr && (addr_i == KEY_ADDR) && (wdata_i == PRE_KEY);
  assign hit_data = wr && (addr_i == DATA_ADDR);
  assign hit_post = wr && (addr_i == KEY_ADDR) && (wdata_i == POST_KEY);

  // any access that is not the expected next step drops back to idle
  always_comb begin
    state_d   = state_q;
    stage_en  = 1'b0;
    commit_en = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (hit_pre) state_d = SEQ_ARMED;
      end
      SEQ_ARMED: begin
        if (req_i) begin
          if (hit_data) begin
            state_d  = SEQ_STAGED;
            stage_en = 1'b1;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      SEQ_STAGED: begin
        if (req_i) begin
          state_d   = SEQ_IDLE;
          commit_en = hit_post;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      shadow_q <= RST_VAL;
      live_o   <= RST_VAL;
      commit_o <= 1'b0;
    end else begin
      state_q  <= state_d;
      commit_o <= commit_en;
      if (stage_en)  shadow_q <= wdata_i[REG_W_P-1:0] & MASK;
      if (commit_en) live_o   <= shadow_q;
    end
  end
endmodule

// File: rtl/clk_key_rdmux.sv
module clk_key_rdmux
  import clk_key_pkg::*;
#(
  parameter int BUS_W_P  = 32,
  parameter int ADDR_W_P = 4,
  parameter int REG_W_P  = 8,
  parameter int N_REG_P  = 2
) (
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W_P-1:0] addr_i,
  input  logic [REG_W_P-1:0]  live_i [N_REG_P],
  output logic [BUS_W_P-1:0]  rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      for (int i = 0; i < N_REG_P; i++) begin
        if (addr_i == ADDR_W_P'(2 * i)) rdata_o[REG_W_P-1:0] = live_i[i];
      end
    end
  end
endmodule

// File: rtl/clk_key_regs.sv
module clk_key_regs
  import clk_key_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [1:0]        clk_src_o,
  output logic [2:0]        core_div_o,
  output logic [2:0]        pd_mode_o,
  output logic              mode_commit_o,
  output logic              pwr_commit_o
);
  logic [REG_W-1:0] live [N_REG];
  logic [N_REG-1:0] commit;

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    clk_key_seq #(
      .BUS_W_P  (BUS_W),
      .ADDR_W_P (ADDR_W),
      .REG_W_P  (REG_W),
      .PRE_KEY  (pre_key(g)),
      .POST_KEY (post_key(g)),
      .KEY_ADDR (key_addr(g)),
      .DATA_ADDR(data_addr(g)),
      .MASK     (wr_mask(g)),
      .RST_VAL  ('0)
    ) seq_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req_i),
      .we_i    (we_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .live_o  (live[g]),
      .commit_o(commit[g])
    );
  end

  clk_key_rdmux #(
    .BUS_W_P (BUS_W),
    .ADDR_W_P(ADDR_W),
    .REG_W_P (REG_W),
    .N_REG_P (N_REG)
  ) rdmux_i (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .live_i (live),
    .rdata_o(rdata_o)
  );

  assign clk_src_o     = live[IDX_MODE][1:0];
  assign core_div_o    = live[IDX_PWR][2:0];
  assign pd_mode_o     = live[IDX_PWR][6:4];
  assign mode_commit_o = commit[IDX_MODE];
  assign pwr_commit_o  = commit[IDX_PWR];
endmodule

// File: rtl/clk_key_regs_chk.sv
module clk_key_regs_chk
  import clk_key_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic [1:0]        clk_src_o,
  input logic [2:0]        core_div_o,
  input logic [2:0]        pd_mode_o,
  input logic              mode_commit_o,
  input logic              pwr_commit_o
);
  AST_MODE_COMMIT_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_commit_o |-> $past(req_i && we_i && addr_i == key_addr(IDX_MODE) && wdata_i == MODE_POST)); // R2

  AST_PWR_COMMIT_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_commit_o |-> $past(req_i && we_i && addr_i == key_addr(IDX_PWR) && wdata_i == PWR_POST)); // R3

  AST_MODE_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_src_o) |-> mode_commit_o); // R4

  AST_PWR_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({core_div_o, pd_mode_o}) |-> pwr_commit_o); // R4

  AST_MODE_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_commit_o |=> !mode_commit_o); // R9

  AST_PWR_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_commit_o |=> !pwr_commit_o); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({mode_commit_o, pwr_commit_o}) <= 1); // R9

  AST_RDATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i || (addr_i != data_addr(IDX_MODE) && addr_i != data_addr(IDX_PWR)))
      |-> (rdata_o == '0)); // R10
endmodule

bind clk_key_regs clk_key_regs_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .clk_src_o    (clk_src_o),
  .core_div_o   (core_div_o),
  .pd_mode_o    (pd_mode_o),
  .mode_commit_o(mode_commit_o),
  .pwr_commit_o (pwr_commit_o)
);

// File: tb/clk_key_regs_tb_top.sv
module clk_key_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [1:0]  clk_src_o;
  logic [2:0]  core_div_o, pd_mode_o;
  logic        mode_commit_o, pwr_commit_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  clk_key_regs dut_i (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(posedge clk_i); #1;
    req_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // call right after the last write of a sequence
  task automatic strobes(logic m, logic p, string tag);
    check({tag, " mode strobe"}, 32'(mode_commit_o), 32'(m));
    check({tag, " pwr strobe"}, 32'(pwr_commit_o), 32'(p));
    @(posedge clk_i); #1;
    check({tag, " strobe drop"}, 32'({mode_commit_o, pwr_commit_o}), 32'd0);
  endtask

  // read monitor: pops expected values in order
  always @(negedge clk_i) begin
    #2;
    if (req_i && !we_i) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R1
    check("R1 clk_src", 32'(clk_src_o), 0);
    check("R1 core_div", 32'(core_div_o), 0);
    check("R1 pd_mode", 32'(pd_mode_o), 0);
    check("R1 strobes", 32'({mode_commit_o, pwr_commit_o}), 0);
    bus_rd(4'd0, 32'h0, "R1 mode read");
    bus_rd(4'd2, 32'h0, "R1 pwr read");

    // R2, R4: mode commit to low-power oscillator
    bus_wr(4'd1, 32'hAA);
    bus_wr(4'd0, 32'h1);
    check("R4 src held before post key", 32'(clk_src_o), 0);
    bus_wr(4'd1, 32'h55);
    check("R2 clk_src", 32'(clk_src_o), 1);
    strobes(1'b1, 1'b0, "R2 R9");
    bus_rd(4'd0, 32'h1, "R2 mode read");

    // R3, R10: power commit with masking
    bus_wr(4'd3, 32'h01);
    bus_wr(4'd2, 32'hFFFF_FF5B);
    check("R4 pwr held before post key", 32'({pd_mode_o, core_div_o}), 0);
    bus_wr(4'd3, 32'hF4);
    check("R3 core_div", 32'(core_div_o), 3);
    check("R3 pd_mode", 32'(pd_mode_o), 5);
    strobes(1'b0, 1'b1, "R3 R9");
    bus_rd(4'd2, 32'h53, "R10 pwr read masked");
    bus_rd(4'd0, 32'h1, "R9 mode untouched by pwr commit");

    // R5: wrong opening key
    bus_wr(4'd1, 32'hAB);
    bus_wr(4'd0, 32'h2);
    bus_wr(4'd1, 32'h55);
    strobes(1'b0, 1'b0, "R5 bad pre");
    bus_rd(4'd0, 32'h1, "R5 bad pre value");
    // R5: wrong closing key
    bus_wr(4'd1, 32'hAA);
    bus_wr(4'd0, 32'h2);
    bus_wr(4'd1, 32'h56);
    strobes(1'b0, 1'b0, "R5 bad post");
    bus_wr(4'd1, 32'h55);
    strobes(1'b0, 1'b0, "R5 late post");
    bus_rd(4'd0, 32'h1, "R5 bad post value");

    // R6: intervening read
    bus_wr(4'd1, 32'hAA);
    bus_rd(4'd2, 32'h53, "R6 read between steps");
    bus_wr(4'd0, 32'h2);
    bus_wr(4'd1, 32'h55);
    strobes(1'b0, 1'b0, "R6 read abort");
    // R6: intervening write elsewhere (also a stray pwr data write, R8)
    bus_wr(4'd1, 32'hAA);
    bus_wr(4'd2, 32'h0);
    bus_wr(4'd0, 32'h2);
    bus_wr(4'd1, 32'h55);
    strobes(1'b0, 1'b0, "R6 write abort");
    bus_rd(4'd0, 32'h1, "R6 mode unchanged");
    bus_rd(4'd2, 32'h53, "R8 stray pwr data ignored");

    // R7: idle gaps
    bus_wr(4'd1, 32'hAA);
    idle(5);
    bus_wr(4'd0, 32'hFFFF_FF02);
    idle(3);
    bus_wr(4'd1, 32'h55);
    check("R7 clk_src", 32'(clk_src_o), 2);
    strobes(1'b1, 1'b0, "R7");
    bus_rd(4'd0, 32'h2, "R7 mode read");

    // R8: data write without keys
    bus_wr(4'd0, 32'h0);
    idle(2);
    check("R8 clk_src", 32'(clk_src_o), 2);
    bus_rd(4'd0, 32'h2, "R8 mode read");

    // R11: abort then restart
    bus_wr(4'd3, 32'h01);
    bus_wr(4'd2, 32'h11);
    bus_wr(4'd3, 32'hF5);
    strobes(1'b0, 1'b0, "R11 aborted");
    bus_wr(4'd3, 32'h01);
    bus_wr(4'd2, 32'h70);
    bus_wr(4'd3, 32'hF4);
    check("R11 pd_mode", 32'(pd_mode_o), 7);
    check("R11 core_div", 32'(core_div_o), 0);
    strobes(1'b0, 1'b1, "R11");
    bus_rd(4'd2, 32'h70, "R11 pwr read");

    // R10: key and unmapped addresses read zero
    bus_rd(4'd1, 32'h0, "R10 mode key read");
    bus_rd(4'd3, 32'h0, "R10 pwr key read");
    bus_rd(4'd9, 32'h0, "R10 unmapped read");

    idle(3);
    check("scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule